// File: doc/BRIEF.md
# FIFO Watermark Data-Request Generator

This block sits between a host register port and a serial byte engine and owns the small byte queue that carries data between them. The host writes bytes into the queue while an outgoing transfer runs and reads bytes out of it while an incoming transfer runs. The engine drains the queue onto the wire, or fills it from the wire, on the other side.

Each clock the block compares the registered entry count against two host-programmed thresholds. It raises a high-water flag for incoming data and a low-water flag for outgoing data. From those flags, and from two residual byte counts supplied by the transfer controller, it derives a data-request flag that tells the host when to service the queue.

Misuse of the host side raises a one-cycle error pulse. This covers an access in the wrong direction or with no transfer running, a push into a full queue, and a pop from an empty one. In pacing mode, a full or empty condition drops the access silently instead of reporting it.

Top module: `fifo_wm_dreq`

## Requirements
- R1: `fill_count` reports the number of queued bytes, 0 to DEPTH (8 by default). After reset the count is 0 and `high_water`, `low_water`, `data_req`, `err_overrun` and `err_invalid` are all 0.
- R2: The queue is first-in first-out in both directions. `eng_tx_data` shows the oldest byte while sending. `host_rdata` shows the oldest byte while receiving, and `host_pop` advances past it.
- R3: While `xfer_active` and `xfer_rd` are 1, `high_water` takes the value (count >= `wm_high`) one clock after that count and threshold are present.
- R4: While receiving, `data_req` becomes ((count >= `wm_high` and count != 0) or `front_left` == 0) one clock later.
- R5: While `xfer_active` is 1 and `xfer_rd` is 0, `low_water` takes the value (count <= `wm_low`) one clock later.
- R6: While sending, `data_req` becomes (`back_left` != 0 and ((DEPTH - count) >= `back_left` or count <= `wm_low`)) one clock later.
- R7: `data_req` is 0 one clock after any cycle in which `xfer_active` is 0, or in which `front_left` and `back_left` are both 0. Each water flag keeps its value while the block is idle or serving the other direction.
- R8: A host push while the queue holds DEPTH bytes, or a host pop while it is empty, changes neither the count nor the contents. Such an access pulses `err_overrun` for one clock, unless `pace_allow` is 1.
- R9: A host push with `xfer_active` 0 or `xfer_rd` 1 is dropped and pulses `err_invalid`. The same holds for a host pop with `xfer_active` 0 or `xfer_rd` 0. `err_invalid` takes precedence over `err_overrun`.
- R10: While sending, `eng_tx_valid` is 1 whenever the queue is non-empty, and `eng_take` removes the oldest byte. While receiving, `eng_rx_ready` is 1 whenever the queue is not full, and `eng_give` stores `eng_rx_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xfer_active | input | 1 | A transfer is in progress |
| xfer_rd | input | 1 | 1 = incoming (read) transfer, 0 = outgoing |
| pace_allow | input | 1 | Drop full/empty accesses without an error |
| wm_high | input | WMW | High-water threshold for incoming data |
| wm_low | input | WMW | Low-water threshold for outgoing data |
| front_left | input | RW | Bytes still to move on the wire side |
| back_left | input | RW | Bytes still to move on the host side |
| host_push | input | 1 | Host writes `host_wdata` into the queue |
| host_wdata | input | DW | Host write byte |
| host_pop | input | 1 | Host consumes the byte on `host_rdata` |
| host_rdata | output | DW | Oldest queued byte for the host |
| eng_tx_valid | output | 1 | A byte is available for the engine to send |
| eng_tx_data | output | DW | Oldest queued byte for the engine |
| eng_take | input | 1 | Engine consumes `eng_tx_data` |
| eng_rx_ready | output | 1 | Queue can accept a received byte |
| eng_rx_data | input | DW | Byte received by the engine |
| eng_give | input | 1 | Engine stores `eng_rx_data` |
| fill_count | output | CW | Number of queued bytes |
| high_water | output | 1 | Receive high-water flag |
| low_water | output | 1 | Send low-water flag |
| data_req | output | 1 | Host service request |
| err_overrun | output | 1 | One-cycle pulse: push to full or pop from empty |
| err_invalid | output | 1 | One-cycle pulse: access in the wrong state |

## Verification
The properties assume that `xfer_rd`, the thresholds and the residual counts change only while the block is not also being asked to evaluate them in the same cycle's comparison. They also assume the engine strobes `eng_take` and `eng_give` only as offered. The stimulus therefore sets direction, thresholds and residuals at a falling edge, before any push or pop of the scenario. It holds them steady while the count settles. It raises the engine strobes only while the matching ready or valid output is visible, apart from the single deliberate give into a full queue.

// File: rtl/fifo_wm_dreq_pkg.sv
// Package for the watermark data-request block.
// Holds the per-cycle access decision record shared by the gate and the top.
package fifo_wm_dreq_pkg;

    // Outcome of the host and engine requests in one cycle.
    typedef struct packed {
        logic wr_en;     // a byte enters the queue
        logic rd_en;     // the oldest byte leaves the queue
        logic bad_use;   // access in the wrong state
        logic ovr;       // push to full or pop from empty, not paced
    } access_t;

endpackage

// File: rtl/fifo_wm_dreq_store.sv
// Circular byte store with an occupancy counter.
// Assumes the caller never asserts wr_en when full or rd_en when empty;
// a simultaneous write and read leaves the count unchanged.
module fifo_wm_dreq_store #(
    parameter int DEPTH = 8,
    parameter int DW    = 8,
    parameter int CW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt_q;

    // Storage write port; contents need no reset.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_data;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (wr_en) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (rd_en) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({wr_en, rd_en})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // Status and head-of-queue view.
    always_comb begin
        head  = mem[rd_ptr];
        count = cnt_q;
        full  = (cnt_q == DEPTH_C);
        empty = (cnt_q == '0);
    end
endmodule

// File: rtl/fifo_wm_dreq_gate.sv
// Access arbiter: decides, from direction, activity and fill state,
// which host and engine requests are honoured and which are errors.
// Assumes only one direction is served at a time, so host and engine
// never both write, and never both read, in one cycle.
module fifo_wm_dreq_gate
    import fifo_wm_dreq_pkg::*;
(
    input  logic    host_push,
    input  logic    host_pop,
    input  logic    eng_take,
    input  logic    eng_give,
    input  logic    active,
    input  logic    rd_dir,
    input  logic    full,
    input  logic    empty,
    input  logic    pace,
    output logic    tx_valid,
    output logic    rx_ready,
    output access_t acc
);
    logic push_bad, pop_bad, push_ok, pop_ok;

    // Classify each request and merge into one decision.
    always_comb begin
        push_bad = host_push && (!active || rd_dir);
        pop_bad  = host_pop  && (!active || !rd_dir);
        push_ok  = host_push && !push_bad && !full;
        pop_ok   = host_pop  && !pop_bad  && !empty;
        tx_valid = active && !rd_dir && !empty;
        rx_ready = active && rd_dir && !full;

        acc.wr_en   = push_ok || (rx_ready && eng_give);
        acc.rd_en   = pop_ok  || (tx_valid && eng_take);
        acc.bad_use = push_bad || pop_bad;
        acc.ovr     = !pace && ((host_push && !push_bad && full) ||
                                (host_pop  && !pop_bad  && empty));
    end
endmodule

// File: rtl/fifo_wm_dreq_flags.sv
// Watermark and data-request evaluator. Flags are registered from the
// registered count and the current residuals, so they trail a count
// change by one clock. Assumes residual width exceeds count width.
module fifo_wm_dreq_flags #(
    parameter int DEPTH = 8,
    parameter int CW    = 8,
    parameter int WMW   = 4,
    parameter int RW    = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [CW-1:0]  count,
    input  logic           active,
    input  logic           rd_dir,
    input  logic [WMW-1:0] wm_high,
    input  logic [WMW-1:0] wm_low,
    input  logic [RW-1:0]  front_left,
    input  logic [RW-1:0]  back_left,
    output logic           high_water,
    output logic           low_water,
    output logic           data_req
);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    logic          hi_n, lo_n, dreq_n;
    logic [CW-1:0] free_c;
    logic [RW-1:0] free_w;

    // Next-state flag terms for the current direction.
    always_comb begin
        free_c = DEPTH_C - count;
        free_w = {{(RW-CW){1'b0}}, free_c};
        hi_n   = count >= {{(CW-WMW){1'b0}}, wm_high};
        lo_n   = count <= {{(CW-WMW){1'b0}}, wm_low};
        if (rd_dir)
            dreq_n = (hi_n && count != '0) || (front_left == '0);
        else
            dreq_n = (back_left != '0) && ((free_w >= back_left) || lo_n);
        if (front_left == '0 && back_left == '0)
            dreq_n = 1'b0;
    end

    // Register the flags; only the active direction's flag moves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            high_water <= 1'b0;
            low_water  <= 1'b0;
            data_req   <= 1'b0;
        end else if (!active) begin
            data_req <= 1'b0;
        end else begin
            if (rd_dir) high_water <= hi_n;
            else        low_water  <= lo_n;
            data_req <= dreq_n;
        end
    end
endmodule

// File: rtl/fifo_wm_dreq.sv
// Top of the watermark data-request block: byte queue, access gate,
// flag evaluator and registered one-cycle error pulses.
// Assumes the transfer controller owns the residual counts and direction.
module fifo_wm_dreq
    import fifo_wm_dreq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int DW    = 8,
    parameter int CW    = 8,
    parameter int WMW   = 4,
    parameter int RW    = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           xfer_active,
    input  logic           xfer_rd,
    input  logic           pace_allow,
    input  logic [WMW-1:0] wm_high,
    input  logic [WMW-1:0] wm_low,
    input  logic [RW-1:0]  front_left,
    input  logic [RW-1:0]  back_left,
    input  logic           host_push,
    input  logic [DW-1:0]  host_wdata,
    input  logic           host_pop,
    output logic [DW-1:0]  host_rdata,
    output logic           eng_tx_valid,
    output logic [DW-1:0]  eng_tx_data,
    input  logic           eng_take,
    output logic           eng_rx_ready,
    input  logic [DW-1:0]  eng_rx_data,
    input  logic           eng_give,
    output logic [CW-1:0]  fill_count,
    output logic           high_water,
    output logic           low_water,
    output logic           data_req,
    output logic           err_overrun,
    output logic           err_invalid
);
    access_t       acc;
    logic          q_full, q_empty;
    logic [DW-1:0] q_head, wr_byte;

    // Write source follows the direction: engine when receiving.
    always_comb wr_byte = xfer_rd ? eng_rx_data : host_wdata;

    fifo_wm_dreq_gate u_gate (
        .host_push (host_push),
        .host_pop  (host_pop),
        .eng_take  (eng_take),
        .eng_give  (eng_give),
        .active    (xfer_active),
        .rd_dir    (xfer_rd),
        .full      (q_full),
        .empty     (q_empty),
        .pace      (pace_allow),
        .tx_valid  (eng_tx_valid),
        .rx_ready  (eng_rx_ready),
        .acc       (acc)
    );

    fifo_wm_dreq_store #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (acc.wr_en),
        .wr_data (wr_byte),
        .rd_en   (acc.rd_en),
        .head    (q_head),
        .count   (fill_count),
        .full    (q_full),
        .empty   (q_empty)
    );

    fifo_wm_dreq_flags #(.DEPTH(DEPTH), .CW(CW), .WMW(WMW), .RW(RW)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .count      (fill_count),
        .active     (xfer_active),
        .rd_dir     (xfer_rd),
        .wm_high    (wm_high),
        .wm_low     (wm_low),
        .front_left (front_left),
        .back_left  (back_left),
        .high_water (high_water),
        .low_water  (low_water),
        .data_req   (data_req)
    );

    // Head byte is visible to whichever side consumes it.
    always_comb begin
        host_rdata  = q_head;
        eng_tx_data = q_head;
    end

    // One-cycle error pulses; misuse outranks full/empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_invalid <= 1'b0;
            err_overrun <= 1'b0;
        end else begin
            err_invalid <= acc.bad_use;
            err_overrun <= acc.ovr && !acc.bad_use;
        end
    end
endmodule

// File: rtl/fifo_wm_dreq_chk.sv
// Property checker for fifo_wm_dreq, attached with bind below.
// Assumes residuals, thresholds and direction are driven synchronously.
module fifo_wm_dreq_chk #(
    parameter int DEPTH = 8,
    parameter int CW    = 8,
    parameter int WMW   = 4,
    parameter int RW    = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           xfer_active,
    input logic           xfer_rd,
    input logic           pace_allow,
    input logic [WMW-1:0] wm_high,
    input logic [WMW-1:0] wm_low,
    input logic [RW-1:0]  front_left,
    input logic [RW-1:0]  back_left,
    input logic           host_push,
    input logic           eng_take,
    input logic           eng_rx_ready,
    input logic [CW-1:0]  fill_count,
    input logic           high_water,
    input logic           low_water,
    input logic           data_req,
    input logic           err_overrun,
    input logic           err_invalid
);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fill_count <= DEPTH_C);

    p_high_water_r3: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_active && xfer_rd |=> high_water == ($past(fill_count) >= CW'($past(wm_high))));

    p_low_water_r5: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_active && !xfer_rd |=> low_water == ($past(fill_count) <= CW'($past(wm_low))));

    p_low_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_active && xfer_rd |=> $stable(low_water));

    p_idle_dreq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_active |=> !data_req);

    p_done_dreq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        front_left == '0 && back_left == '0 |=> !data_req);

    p_pace_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pace_allow |=> !err_overrun);

    p_full_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_active && !xfer_rd && host_push && !eng_take && fill_count == DEPTH_C
        |=> fill_count == DEPTH_C);

    p_push_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        host_push && !xfer_active |=> err_invalid && !err_overrun);

    p_rx_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fill_count == DEPTH_C |-> !eng_rx_ready);
endmodule

bind fifo_wm_dreq fifo_wm_dreq_chk #(.DEPTH(DEPTH), .CW(CW), .WMW(WMW), .RW(RW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .xfer_active  (xfer_active),
    .xfer_rd      (xfer_rd),
    .pace_allow   (pace_allow),
    .wm_high      (wm_high),
    .wm_low       (wm_low),
    .front_left   (front_left),
    .back_left    (back_left),
    .host_push    (host_push),
    .eng_take     (eng_take),
    .eng_rx_ready (eng_rx_ready),
    .fill_count   (fill_count),
    .high_water   (high_water),
    .low_water    (low_water),
    .data_req     (data_req),
    .err_overrun  (err_overrun),
    .err_invalid  (err_invalid)
);

// File: tb/test_fifo_wm_dreq.sv
// Self-checking bench: a vector table for the flag rules, then directed
// tests for reset, ordering, errors, pacing and idle behaviour.
module test_fifo_wm_dreq;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 12;
    // {rd, cnt[3:0], wm[3:0], front[15:0], back[15:0], hi, lo, dreq}
    localparam logic [43:0] VEC [NV] = '{
        {1'b1, 4'd3, 4'd4, 16'd5, 16'd5, 1'b0, 1'b0, 1'b0},
        {1'b1, 4'd4, 4'd4, 16'd5, 16'd5, 1'b1, 1'b0, 1'b1},
        {1'b1, 4'd0, 4'd0, 16'd5, 16'd5, 1'b1, 1'b0, 1'b0},
        {1'b1, 4'd0, 4'd4, 16'd0, 16'd3, 1'b0, 1'b0, 1'b1},
        {1'b1, 4'd2, 4'd1, 16'd0, 16'd0, 1'b1, 1'b0, 1'b0},
        {1'b1, 4'd8, 4'd8, 16'd2, 16'd9, 1'b1, 1'b0, 1'b1},
        {1'b0, 4'd5, 4'd2, 16'd9, 16'd3, 1'b0, 1'b0, 1'b1},
        {1'b0, 4'd6, 4'd2, 16'd5, 16'd3, 1'b0, 1'b0, 1'b0},
        {1'b0, 4'd2, 4'd2, 16'd5, 16'd10, 1'b0, 1'b1, 1'b1},
        {1'b0, 4'd0, 4'd0, 16'd4, 16'd0, 1'b0, 1'b1, 1'b0},
        {1'b0, 4'd8, 4'd7, 16'd1, 16'd1, 1'b0, 1'b0, 1'b0},
        {1'b0, 4'd1, 4'd3, 16'd0, 16'd0, 1'b0, 1'b1, 1'b0}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic xfer_active = 1'b0, xfer_rd = 1'b0, pace_allow = 1'b0;
    logic [3:0] wm_high = '0, wm_low = '0;
    logic [15:0] front_left = '0, back_left = '0;
    logic host_push = 1'b0, host_pop = 1'b0, eng_take = 1'b0, eng_give = 1'b0;
    logic [7:0] host_wdata = '0, eng_rx_data = '0, host_rdata, eng_tx_data;
    logic eng_tx_valid, eng_rx_ready, high_water, low_water, data_req;
    logic err_overrun, err_invalid;
    logic [7:0] fill_count;
    int n_chk = 0, n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fifo_wm_dreq i_fifo_wm_dreq (
        .clk(clk), .rst_n(rst_n), .xfer_active(xfer_active), .xfer_rd(xfer_rd),
        .pace_allow(pace_allow), .wm_high(wm_high), .wm_low(wm_low),
        .front_left(front_left), .back_left(back_left),
        .host_push(host_push), .host_wdata(host_wdata), .host_pop(host_pop),
        .host_rdata(host_rdata), .eng_tx_valid(eng_tx_valid),
        .eng_tx_data(eng_tx_data), .eng_take(eng_take),
        .eng_rx_ready(eng_rx_ready), .eng_rx_data(eng_rx_data),
        .eng_give(eng_give), .fill_count(fill_count),
        .high_water(high_water), .low_water(low_water), .data_req(data_req),
        .err_overrun(err_overrun), .err_invalid(err_invalid)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FIFO-TB FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; xfer_active = 1'b0; pace_allow = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic push_one(input logic [7:0] d);
        @(negedge clk); host_push = 1'b1; host_wdata = d;
        @(negedge clk); host_push = 1'b0;
    endtask

    task automatic pop_one();
        @(negedge clk); host_pop = 1'b1;
        @(negedge clk); host_pop = 1'b0;
    endtask

    task automatic give_one(input logic [7:0] d);
        @(negedge clk); eng_give = 1'b1; eng_rx_data = d;
        @(negedge clk); eng_give = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FIFO-TB FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset();
        chk("R1 count", 16'(fill_count), 16'd0);
        chk("R1 flags", {13'd0, high_water, low_water, data_req}, 16'd0);
        chk("R1 errs", {14'd0, err_overrun, err_invalid}, 16'd0);

        // Vector table: R3 R4 R5 R6 R7
        for (int v = 0; v < NV; v++) begin
            do_reset();
            xfer_active = 1'b1;
            xfer_rd    = VEC[v][43];
            wm_high    = VEC[v][38:35];
            wm_low     = VEC[v][38:35];
            front_left = VEC[v][34:19];
            back_left  = VEC[v][18:3];
            for (int k = 0; k < int'(VEC[v][42:39]); k++) begin
                if (VEC[v][43]) give_one(8'(k));
                else            push_one(8'(k));
            end
            repeat (2) @(negedge clk);
            chk("R1 vec count", 16'(fill_count), 16'(VEC[v][42:39]));
            chk("R3 vec high_water", 16'(high_water), 16'(VEC[v][2]));
            chk("R5 vec low_water", 16'(low_water), 16'(VEC[v][1]));
            chk(VEC[v][43] ? "R4 vec data_req" : "R6 vec data_req",
                16'(data_req), 16'(VEC[v][0]));
        end

        // R2 send order, R10 engine take
        do_reset();
        xfer_active = 1'b1; xfer_rd = 1'b0; front_left = 16'd9; back_left = 16'd9;
        push_one(8'hA5);
        push_one(8'h3C);
        chk("R10 tx_valid", 16'(eng_tx_valid), 16'd1);
        chk("R2 tx head", 16'(eng_tx_data), 16'h00A5);
        @(negedge clk); eng_take = 1'b1;
        @(negedge clk); eng_take = 1'b0;
        chk("R2 tx next", 16'(eng_tx_data), 16'h003C);
        chk("R10 count after take", 16'(fill_count), 16'd1);

        // R8 push to full with and without pacing
        for (int k = 0; k < 7; k++) push_one(8'h50 + 8'(k));
        chk("R8 filled", 16'(fill_count), 16'd8);
        push_one(8'hEE);
        chk("R8 overrun pulse", 16'(err_overrun), 16'd1);
        chk("R8 count held", 16'(fill_count), 16'd8);
        chk("R8 head kept", 16'(eng_tx_data), 16'h003C);
        @(negedge clk);
        chk("R8 pulse one cycle", 16'(err_overrun), 16'd0);
        pace_allow = 1'b1;
        push_one(8'hEF);
        chk("R8 paced quiet", {14'd0, err_overrun, err_invalid}, 16'd0);
        chk("R8 paced count", 16'(fill_count), 16'd8);
        pace_allow = 1'b0;

        // R9 wrong-state accesses
        xfer_rd = 1'b1;
        push_one(8'h11);
        chk("R9 push in read", {14'd0, err_overrun, err_invalid}, 16'd1);
        chk("R9 push in read count", 16'(fill_count), 16'd8);
        xfer_rd = 1'b0;
        pop_one();
        chk("R9 pop in write", 16'(err_invalid), 16'd1);
        chk("R9 pop in write count", 16'(fill_count), 16'd8);
        xfer_active = 1'b0;
        push_one(8'h22);
        chk("R9 push idle", 16'(err_invalid), 16'd1);
        pop_one();
        chk("R9 pop idle", 16'(err_invalid), 16'd1);
        chk("R9 idle count", 16'(fill_count), 16'd8);

        // R2 receive order, R8 empty pop
        do_reset();
        xfer_active = 1'b1; xfer_rd = 1'b1; front_left = 16'd9; back_left = 16'd9;
        give_one(8'h11);
        give_one(8'h22);
        chk("R2 rx head", 16'(host_rdata), 16'h0011);
        pop_one();
        chk("R2 rx next", 16'(host_rdata), 16'h0022);
        chk("R2 rx count", 16'(fill_count), 16'd1);
        pop_one();
        chk("R2 rx empty", 16'(fill_count), 16'd0);
        pop_one();
        chk("R8 underrun pulse", {14'd0, err_overrun, err_invalid}, 16'd2);
        pace_allow = 1'b1;
        pop_one();
        chk("R8 paced underrun", 16'(err_overrun), 16'd0);
        pace_allow = 1'b0;

        // R10 engine refused when full
        do_reset();
        xfer_active = 1'b1; xfer_rd = 1'b1;
        for (int k = 0; k < 8; k++) give_one(8'(k));
        chk("R10 rx_ready full", 16'(eng_rx_ready), 16'd0);
        give_one(8'hFF);
        chk("R10 full count", 16'(fill_count), 16'd8);

        // R7 idle clears data_req, high_water held
        do_reset();
        xfer_active = 1'b1; xfer_rd = 1'b1; wm_high = 4'd0;
        front_left = 16'd0; back_left = 16'd3;
        repeat (2) @(negedge clk);
        chk("R4 front zero dreq", 16'(data_req), 16'd1);
        xfer_active = 1'b0;
        repeat (2) @(negedge clk);
        chk("R7 idle dreq", 16'(data_req), 16'd0);
        chk("R7 high held", 16'(high_water), 16'd1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule